// File: doc/BRIEF.md
# Deferred-Fold Ones'-Complement Word Accumulator

This block sums a stream of unsigned words modulo 2^DATA_W−1 (2^32−1 by default). This is the arithmetic that a Fletcher-style checksum uses for its running sum. It does not reduce after every word. It adds each word into a wider register whose spare upper bits count how often the low DATA_W bits have wrapped.

A fold adds those guard bits back into the low bits. It happens once per block of BLOCK_LEN accepted words, and again when a word is tagged as the end of a message. During a fold the input port stalls for two cycles. In the first cycle the 33-bit sum of the low word and the guard count is registered. In the second cycle that sum is reduced by selecting either S or S+1, according to the carry out of S+1, and the reduced value is written back.

A producer streams words with a valid/ready handshake and marks the final word of each message. The block raises a one-cycle done strobe with the fully reduced residue. It then starts the next message from zero. A synchronous clear input discards a partial message.

Top module: `ones_mod_accum`

## Requirements
- R1: After reset `s_ready` is 1, `sum_done` is 0 and `sum_out` is 0.
- R2: On `sum_done`, `sum_out` equals the sum of all words of the message modulo 2^DATA_W−1, and it always lies in 0 .. 2^DATA_W−2, so it is never all-ones.
- R3: A message whose words total exactly 2^DATA_W−1, or any multiple of it, yields 0. Examples are a single all-ones word, or 0x80000000 plus 0x7FFFFFFF.
- R4: After every BLOCK_LEN accepted words, and after the word accepted with `s_last`=1, `s_ready` is 0 for exactly two cycles. A word offered during those cycles is neither lost nor counted twice.
- R5: `sum_done` is high in the second cycle after the clock edge that accepts the word carrying `s_last`=1. A message that ends part way through a block is folded in the same way.
- R6: `sum_done` lasts one cycle. `sum_out` keeps its value until the next `sum_done`.
- R7: `clr`=1 at a clock edge discards the partial sum and the word count, leaves `sum_out` unchanged, and gives `s_ready`=1 in the next cycle. The next message starts from zero.
- R8: Cycles with `s_valid`=0 leave the sum unchanged, whatever `s_data` carries.
- R9: After a message completes, the next message starts from zero with no clear.
- R10: BLOCK_LEN may be set from 1 to 1024. The accumulator has DATA_W + ceil(log2(BLOCK_LEN+1)) bits, so it cannot overflow within a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the message in progress |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word; low during folds |
| s_data | input | DATA_W | Unsigned input word |
| s_last | input | 1 | Word is the last of its message |
| sum_out | output | DATA_W | Reduced residue of the last completed message |
| sum_done | output | 1 | One-cycle strobe when sum_out is updated |

## Verification
The properties assume the following about the inputs:
- Reset is held for at least one edge before use.
- A producer keeps `s_data` and `s_last` steady while a word waits for `s_ready`.
- `clr` may cut a fold short, so the stall-length property is only armed when no clear accompanies the start of a fold.

The stimulus holds every word until it is accepted and leaves random idle gaps between words. It pulses the clear only between folds, while a message is partly sent. Expected residues come from a model that reduces after every single add. That model is given messages that cross several folds, that end exactly on a block boundary, and that total exactly the all-ones value.

// File: rtl/mod_acc_pkg.sv
package mod_acc_pkg;
  // Phase of the accumulate/fold sequence
  typedef enum logic [1:0] {
    PH_SUM    = 2'd0,  // accepting words
    PH_FOLD_A = 2'd1,  // register low word + guard count
    PH_FOLD_B = 2'd2   // conditional increment and write back
  } phase_e;
endpackage

// File: rtl/mod_acc_ctrl.sv
module mod_acc_ctrl
  import mod_acc_pkg::*;
#(
  parameter int BLOCK_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic s_valid,
  input  logic s_last,
  output logic s_ready,
  output logic take,
  output logic fold_load,
  output logic fold_commit,
  output logic msg_end
);
  localparam int CNT_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             end_flag;

  assign s_ready     = (phase == PH_SUM);
  assign take        = s_valid & s_ready & ~clr;
  assign fold_load   = (phase == PH_FOLD_A);
  assign fold_commit = (phase == PH_FOLD_B);
  assign msg_end     = end_flag;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase    <= PH_SUM;
      cnt      <= '0;
      end_flag <= 1'b0;
    end else begin
      unique case (phase)
        PH_SUM: begin
          if (take) begin
            if (s_last || cnt == LAST_IDX) begin
              phase    <= PH_FOLD_A;
              cnt      <= '0;
              end_flag <= s_last;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_FOLD_A: phase <= PH_FOLD_B;
        PH_FOLD_B: begin
          phase    <= PH_SUM;
          end_flag <= 1'b0;
        end
        default: phase <= PH_SUM;
      endcase
    end
  end
endmodule

// File: rtl/mod_acc_fold.sv
module mod_acc_fold #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W:0]   s,
  output logic [DATA_W-1:0] r
);
  logic [DATA_W:0] inc;

  // S+1 carrying past the top data bit means S >= 2^DATA_W-1
  always_comb begin
    inc = s + 1'b1;
    r   = inc[DATA_W] ? inc[DATA_W-1:0] : s[DATA_W-1:0];
  end
endmodule

// File: rtl/mod_acc_sum.sv
module mod_acc_sum #(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [DATA_W-1:0] s_data,
  input  logic              fold_load,
  input  logic              fold_commit,
  input  logic              msg_end,
  output logic [DATA_W-1:0] sum_out,
  output logic              sum_done
);
  localparam int ACC_W = DATA_W + GUARD_W;

  logic [ACC_W-1:0]  acc;
  logic [DATA_W:0]   stage;
  logic [DATA_W-1:0] folded;

  mod_acc_fold #(.DATA_W(DATA_W)) u_fold (
    .s (stage),
    .r (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      stage    <= '0;
      sum_out  <= '0;
      sum_done <= 1'b0;
    end else begin
      sum_done <= 1'b0;
      if (clr) begin
        acc <= '0;
      end else if (take) begin
        acc <= acc + {{GUARD_W{1'b0}}, s_data};
      end else if (fold_load) begin
        stage <= {1'b0, acc[DATA_W-1:0]}
               + {{(DATA_W + 1 - GUARD_W){1'b0}}, acc[ACC_W-1:DATA_W]};
      end else if (fold_commit) begin
        if (msg_end) begin
          acc      <= '0;
          sum_out  <= folded;
          sum_done <= 1'b1;
        end else begin
          acc <= {{GUARD_W{1'b0}}, folded};
        end
      end
    end
  end
endmodule

// File: rtl/ones_mod_accum.sv
module ones_mod_accum #(
  parameter int DATA_W    = 32,
  parameter int BLOCK_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic [DATA_W-1:0] sum_out,
  output logic              sum_done
);
  // Guard bits hold BLOCK_LEN words plus the carried residue (R10)
  localparam int GUARD_W = $clog2(BLOCK_LEN + 1);

  logic take, fold_load, fold_commit, msg_end;

  mod_acc_ctrl #(.BLOCK_LEN(BLOCK_LEN)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .s_valid     (s_valid),
    .s_last      (s_last),
    .s_ready     (s_ready),
    .take        (take),
    .fold_load   (fold_load),
    .fold_commit (fold_commit),
    .msg_end     (msg_end)
  );

  mod_acc_sum #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_sum (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .take        (take),
    .s_data      (s_data),
    .fold_load   (fold_load),
    .fold_commit (fold_commit),
    .msg_end     (msg_end),
    .sum_out     (sum_out),
    .sum_done    (sum_done)
  );
endmodule

// File: rtl/ones_mod_accum_chk.sv
module ones_mod_accum_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              s_ready,
  input logic [DATA_W-1:0] sum_out,
  input logic              sum_done
);
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    sum_done |-> (sum_out != {DATA_W{1'b1}}));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sum_done |=> !sum_done);  // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !sum_done |-> $stable(sum_out));  // R6
  AST_FOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ($fell(s_ready) && !clr) |=> !s_ready);  // R4
  AST_FOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && $past(!s_ready)) |=> s_ready);  // R4
  AST_DONE_AFTER_FOLD: assert property (@(posedge clk) disable iff (rst)
    sum_done |-> $past(!s_ready));  // R5
  AST_CLR_READY: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> s_ready);  // R7
endmodule

bind ones_mod_accum ones_mod_accum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .s_ready  (s_ready),
  .sum_out  (sum_out),
  .sum_done (sum_done)
);

// File: tb/ones_mod_accum_tb.sv
`timescale 1ns/1ps
module ones_mod_accum_tb;
  localparam int DW = 32;
  localparam int BL = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic          s_ready;
  logic [DW-1:0] sum_out;
  logic          sum_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  int pulse_bad = 0;
  int stall_run = 0;
  int stall_runs = 0;
  int stall_bad = 0;
  logic          prev_done = 1'b0;
  logic [DW-1:0] done_val = '0;
  logic [DW-1:0] last_result = '0;
  logic [DW-1:0] msg_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  ones_mod_accum #(.DATA_W(DW), .BLOCK_LEN(BL)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .sum_out(sum_out), .sum_done(sum_done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Observation away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sum_done) begin
        done_cnt++;
        done_val = sum_out;
        done_cyc = cyc;
        if (prev_done) pulse_bad++;
      end
      prev_done = sum_done;
      if (!s_ready) stall_run++;
      else if (stall_run != 0) begin
        stall_runs++;
        if (stall_run != 2) stall_bad++;
        stall_run = 0;
      end
    end
  end

  function automatic logic [DW-1:0] ref_add(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= {1'b0, {DW{1'b1}}}) t = t - {1'b0, {DW{1'b1}}};
    return t[DW-1:0];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after acceptance
  task automatic send_word(logic [DW-1:0] w, logic last);
    s_valid = 1'b1; s_data = w; s_last = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    s_valid = 1'b0; s_last = 1'b0; s_data = $urandom;  // R8 junk while idle
  endtask

  task automatic run_msg(int max_gap);
    logic [DW-1:0] exp_v = '0;
    int d0, r0, n;
    n  = msg_q.size();
    d0 = done_cnt;
    r0 = stall_runs;
    check(sum_out == last_result, "R6", "result held", sum_out, last_result);
    foreach (msg_q[i]) exp_v = ref_add(exp_v, msg_q[i]);
    foreach (msg_q[i]) begin
      send_word(msg_q[i], i == n - 1);
      if (max_gap > 0) repeat ($urandom_range(max_gap, 0)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(done_cnt == d0 + 1, "R6", "done count", done_cnt - d0, 1);
    check(done_val == exp_v, "R2", "residue", done_val, exp_v);
    check(done_cyc - acc_cyc == 2 || max_gap > 0, "R5", "done latency",
          done_cyc - acc_cyc, 2);
    check(stall_runs - r0 == (n + BL - 1) / BL, "R4", "fold count",
          stall_runs - r0, (n + BL - 1) / BL);
    check(stall_bad == 0, "R4", "stall length", stall_bad, 0);
    check(pulse_bad == 0, "R6", "done pulse", pulse_bad, 0);
    last_result = exp_v;
    msg_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(s_ready == 1'b1, "R1", "ready", s_ready, 1);
    check(sum_done == 1'b0, "R1", "done", sum_done, 0);
    check(sum_out == '0, "R1", "result", sum_out, 0);

    // R3 single all-ones word
    msg_q = '{32'hFFFF_FFFF}; run_msg(0);
    check(last_result == 0, "R3", "all-ones word", done_val, 0);
    // R3 two words adding to all-ones
    msg_q = '{32'h8000_0000, 32'h7FFF_FFFF}; run_msg(0);
    check(done_val == 0, "R3", "pair to all-ones", done_val, 0);
    // R2 wrap past all-ones
    msg_q = '{32'hFFFF_FFFE, 32'h0000_0002}; run_msg(0);
    // R3 R4 many all-ones across several folds
    for (int i = 0; i < 20; i++) msg_q.push_back(32'hFFFF_FFFF);
    run_msg(0);
    // R4 R5 message exactly one block, back to back (R9)
    for (int i = 0; i < BL; i++) msg_q.push_back(32'hF000_0000 + i);
    run_msg(0);

    // R7 clear mid-message
    send_word(32'h1234_5678, 1'b0);
    send_word(32'hFFFF_0000, 1'b0);
    send_word(32'h0000_FFFF, 1'b0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(s_ready == 1'b1, "R7", "ready after clear", s_ready, 1);
    check(sum_out == last_result, "R7", "result kept", sum_out, last_result);
    msg_q = '{32'd5, 32'd6}; run_msg(0);
    check(done_val == 32'd11, "R7", "fresh after clear", done_val, 11);

    // R8 R9 random messages with gaps and biased words
    for (int m = 0; m < 40; m++) begin
      int len = $urandom_range(25, 1);
      for (int i = 0; i < len; i++) begin
        int k = $urandom_range(7, 0);
        msg_q.push_back(k == 0 ? 32'hFFFF_FFFF : (k == 1 ? 32'h0 : $urandom));
      end
      run_msg(m % 2 == 0 ? 2 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule